// File: doc/BRIEF.md
# Word Address Counter for a Serial EEPROM

This block holds the internal data word address of a small two-wire serial EEPROM. The address is 8 to 11 bits wide, set by a parameter. The serial control logic gives it three one-cycle strobes. The first loads a new address: the page-select bits carried in the device address byte become the upper bits, and the received word address byte becomes the low eight. The second strobe steps the address after a byte is read. The third steps it after a byte is written.

The two steps wrap differently. A write step advances only the offset inside the current page, so a long burst of page writes folds back to the start of the same page. A read step advances the whole address, so a sequential read runs off the last byte of the array to address zero. Between transactions the counter holds its value, so it always points one past the last location accessed. A current address read therefore returns the next location.

The next address comes from a priority decoder that picks one operation: hold, load, read step or write step. An address engine works out the result for that operation, and a register holds the address.

Top module: `word_addr_ctr`

## Requirements
- R1: After reset the address output is zero.
- R2: A load strobe sets the address, one clock later, to the page-select bits (the low ADDR_W-8 bits of `page_sel_i`, as the most significant bits) followed by `word_byte_i` as the low 8 bits.
- R3: A write step adds one to the low in-page offset bits, modulo the page size. The offset is 3 bits when ADDR_W is 8 and 4 bits otherwise.
- R4: A write step leaves every address bit above the in-page offset unchanged.
- R5: A read step adds one to the whole address modulo 2^ADDR_W, so the all-ones address is followed by zero.
- R6: In a cycle with no strobe the address keeps its value, for any number of cycles.
- R7: A load takes priority over both steps when they arrive in the same cycle.
- R8: When a read step and a write step arrive together without a load, the read rule of R5 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load a new address |
| rd_step_i | input | 1 | Advance after a byte is read |
| wr_step_i | input | 1 | Advance after a byte is written |
| page_sel_i | input | 3 | Page-select bits from the device address byte |
| word_byte_i | input | 8 | Received word address byte |
| addr_o | output | ADDR_W | Current word address |

## Verification
A wrong internal state always shows on `addr_o` one clock after the strobe that caused it, because the register drives the output directly. A wrong wrap rule shows up only at a page boundary (0x53F to 0x530) or at the top of the array (0x7FF to 0x000), so the stimulus crosses both on purpose. A wrong priority shows only when strobes collide, so loads are combined with steps and the two steps are combined with each other. The check after a collision uses a starting address whose result under the read rule differs from its result under the write rule.

// File: rtl/wac_pkg.sv
package wac_pkg;
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_LOAD    = 2'd1,
        OP_RD_STEP = 2'd2,
        OP_WR_STEP = 2'd3
    } wac_op_e;

    function automatic int unsigned page_ofs_bits(input int unsigned addr_w);
        return (addr_w <= 8) ? 3 : 4;
    endfunction
endpackage

// File: rtl/wac_op_decode.sv
module wac_op_decode
    import wac_pkg::*;
(
    input  logic    load_i,
    input  logic    rd_step_i,
    input  logic    wr_step_i,
    output wac_op_e op_o
);
    // Fixed priority: load, then read step, then write step.
    always_comb begin
        if (load_i)         op_o = OP_LOAD;
        else if (rd_step_i) op_o = OP_RD_STEP;
        else if (wr_step_i) op_o = OP_WR_STEP;
        else                op_o = OP_HOLD;
    end
endmodule

// File: rtl/wac_next_addr.sv
module wac_next_addr
    import wac_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned OFS_W  = page_ofs_bits(ADDR_W)
) (
    input  wac_op_e           op_i,
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [2:0]        page_sel_i,
    input  logic [7:0]        word_byte_i,
    output logic [ADDR_W-1:0] nxt_o
);
    logic [ADDR_W-1:0] load_val;
    logic [ADDR_W-1:0] rd_val;
    logic [ADDR_W-1:0] wr_val;
    logic [OFS_W-1:0]  ofs_inc;

    generate
        if (ADDR_W > 8) begin : g_paged
            assign load_val = {page_sel_i[ADDR_W-9:0], word_byte_i};
        end else begin : g_flat
            logic [2:0] unused_sel;
            assign unused_sel = page_sel_i;
            assign load_val   = word_byte_i[ADDR_W-1:0];
        end
    endgenerate

    assign rd_val  = cur_i + {{(ADDR_W-1){1'b0}}, 1'b1};
    assign ofs_inc = cur_i[OFS_W-1:0] + {{(OFS_W-1){1'b0}}, 1'b1};
    assign wr_val  = {cur_i[ADDR_W-1:OFS_W], ofs_inc};

    always_comb begin
        unique case (op_i)
            OP_LOAD:    nxt_o = load_val;
            OP_RD_STEP: nxt_o = rd_val;
            OP_WR_STEP: nxt_o = wr_val;
            default:    nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/word_addr_ctr.sv
module word_addr_ctr
    import wac_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              rd_step_i,
    input  logic              wr_step_i,
    input  logic [2:0]        page_sel_i,
    input  logic [7:0]        word_byte_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int unsigned OFS_W = page_ofs_bits(ADDR_W);

    wac_op_e           op;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;

    wac_op_decode i_dec (
        .load_i    (load_i),
        .rd_step_i (rd_step_i),
        .wr_step_i (wr_step_i),
        .op_o      (op)
    );

    wac_next_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_nxt (
        .op_i        (op),
        .cur_i       (addr_q),
        .page_sel_i  (page_sel_i),
        .word_byte_i (word_byte_i),
        .nxt_o       (addr_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    always_comb addr_o = addr_q;

    // R2, R7: a load wins and lands one cycle later
    a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o[7:0] == $past(word_byte_i));

    // R5, R8: read step advances the full address
    a_r5_read_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step_i && !load_i) |=> addr_o == ADDR_W'($past(addr_o) + 1));

    // R4: write step keeps the page
    a_r4_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step_i && !rd_step_i && !load_i)
        |=> addr_o[ADDR_W-1:OFS_W] == $past(addr_o[ADDR_W-1:OFS_W]));

    // R3: write step advances the offset modulo the page
    a_r3_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step_i && !rd_step_i && !load_i)
        |=> addr_o[OFS_W-1:0] == OFS_W'($past(addr_o[OFS_W-1:0]) + 1));

    // R6: idle cycles hold the address
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !rd_step_i && !wr_step_i) |=> $stable(addr_o));
endmodule

// File: tb/test_word_addr_ctr.sv
module test_word_addr_ctr;
    localparam int unsigned AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0, rd_step_i = 1'b0, wr_step_i = 1'b0;
    logic [2:0]    page_sel_i = '0;
    logic [7:0]    word_byte_i = '0;
    logic [AW-1:0] addr_o;

    int checks = 0;
    int fails  = 0;
    logic [AW-1:0] model = '0;

    typedef struct {
        logic [AW-1:0] exp;
        string         req;
    } item_t;
    item_t sbq[$];

    always #2 clk = ~clk;

    word_addr_ctr #(.ADDR_W(AW)) i_word_addr_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .rd_step_i(rd_step_i),
        .wr_step_i(wr_step_i), .page_sel_i(page_sel_i),
        .word_byte_i(word_byte_i), .addr_o(addr_o)
    );

    // Monitor: one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (addr_o !== it.exp) begin
                fails++;
                $display("FAIL %s: addr actual %h expected %h", it.req, addr_o, it.exp);
            end
        end
    end

    // Driver: apply one cycle of strobes at the falling edge, push the result
    task automatic step(input bit ld, input bit rd, input bit wr,
                        input logic [2:0] ps, input logic [7:0] wb, input string req);
        @(negedge clk);
        load_i = ld; rd_step_i = rd; wr_step_i = wr;
        page_sel_i = ps; word_byte_i = wb;
        if (ld)      model = {ps, wb};
        else if (rd) model = model + 11'd1;
        else if (wr) model = {model[AW-1:4], model[3:0] + 4'd1};
        sbq.push_back('{model, req});
    endtask

    task automatic idle(input string req);
        step(0, 0, 0, 3'b000, 8'h00, req);
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #5;
        checks++;
        if (addr_o !== '0) begin
            fails++;
            $display("FAIL R1: reset addr actual %h expected 000", addr_o);
        end
        @(negedge clk); rst_n = 1'b1;
        idle("R1");
        step(1, 0, 0, 3'b101, 8'h3C, "R2");          // 0x53C
        step(0, 1, 0, 3'b000, 8'h00, "R5");          // 0x53D
        step(0, 0, 1, 3'b000, 8'h00, "R3");          // 0x53E
        step(0, 0, 1, 3'b000, 8'h00, "R3");          // 0x53F
        step(0, 0, 1, 3'b000, 8'h00, "R4");          // wraps to 0x530
        for (int i = 0; i < 20; i++) step(0, 0, 1, 3'b000, 8'h00, "R4");
        for (int i = 0; i < 10; i++) idle("R6");
        step(1, 0, 0, 3'b111, 8'hFE, "R2");          // 0x7FE
        step(0, 1, 0, 3'b000, 8'h00, "R5");          // 0x7FF
        step(0, 1, 0, 3'b000, 8'h00, "R5");          // 0x000
        step(0, 1, 0, 3'b000, 8'h00, "R5");          // 0x001
        step(1, 1, 1, 3'b010, 8'h5A, "R7");          // load wins
        step(1, 1, 0, 3'b001, 8'h2F, "R7");          // 0x12F
        step(0, 1, 1, 3'b000, 8'h00, "R8");          // 0x130, not 0x120
        step(1, 0, 1, 3'b011, 8'h0F, "R7");          // 0x30F
        step(0, 0, 1, 3'b000, 8'h00, "R3");          // 0x300
        for (int i = 0; i < 5; i++) idle("R6");
        step(0, 1, 0, 3'b000, 8'h00, "R5");          // 0x301
        idle("R6");
        @(negedge clk); @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule